// File: doc/BRIEF.md
# Calendar Clock with Masked Alarm

This block keeps wall-clock time as six binary counters (second, minute, hour, day, month, year) that advance once per second. The one-second tick comes from an internal prescaler that divides the input clock by a parameter. A host reaches the block through a small register window: one write port and one read port with a one-cycle read latency. Through this window the host sees a shadow copy of the time, six alarm fields, a six-bit alarm field mask and a four-bit control register.

Three control bits act on the time itself. A load request copies the host's shadow fields into the counters on the next tick and then clears itself. A refresh-hold bit stops the per-tick copy of the counters into the shadow fields, so the host can stage a new time without it being overwritten. A freeze bit stops counting and alarm checking. A fourth bit arms the alarm.

While the alarm is armed, each tick compares every unmasked field of the time that the counters take at that tick against its alarm field. A full match pulls the active-low open-drain alarm line low. The line stays low until the host pulses the clear input.

Top module: `cal_clock_alarm`

## Requirements
- R1: A one-cycle pulse on `tick_o` occurs every TICK_DIV clock cycles. Outside a tick the counters hold. On a tick with no load and no freeze they advance by exactly one second.
- R2: Second and minute run 0..59 and wrap to 0 with a carry into the next field. Hour runs 0..23 and wraps to 0 with a carry into the day.
- R3: Day starts at 1. After day 30 in months 4, 6, 9 and 11, and after day 31 in every other month except February, the day returns to 1 and the month advances. February ends after day 29 when year bits [1:0] are 00, and after day 28 otherwise.
- R4: Month runs 1..12. Leaving month 12 sets month to 1 and increments the 8-bit year, which wraps from 255 to 0.
- R5: When control bit 0 (load) is set, the next tick copies the six shadow fields into the counters instead of incrementing, even while frozen. The same tick clears bit 0.
- R6: While control bit 1 (refresh hold) is 0, every tick writes the new counter values into the shadow fields. While it is 1, the shadow fields keep what the host wrote.
- R7: While control bit 2 (freeze) is 1, ticks neither advance the counters nor evaluate the alarm. While control bit 3 (alarm arm) is 0, the alarm is never evaluated.
- R8: On an armed, unfrozen tick, `alarm_n` goes to 0 when every field whose mask bit is 1 equals its alarm field. Mask bit 0 is second, 1 minute, 2 hour, 3 day, 4 month, 5 year. `alarm_n` stays 0 until `alarm_clr` is high at a clock edge. A match on the same edge as a clear keeps it at 0.
- R9: Reset sets the counters to 00:00:00, day 1, month 1, year 0. It sets the shadow second and the alarm second to 0xFF, the other shadow and alarm fields to 0, the mask to 0x3F, control to 0 and `alarm_n` to 1.
- R10: Register addresses are as follows. 0 is control (bits 3:0). 1 is the mask (bits 5:0). 2..7 are the shadow second, minute, hour, day, month and year. 8..13 are the alarm fields in the same order. Other addresses read 0. `rd_data` shows the register selected by `rd_addr` one cycle later. A host write wins over a refresh or a self-clear on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after `rd_addr` |
| alarm_clr | input | 1 | Releases the alarm line |
| tick_o | output | 1 | One-second pulse |
| alarm_n | output | 1 | Alarm line; 0 means pull low, 1 means released |

## Verification
The hardest case to reach is the tick on which several rules meet. These are a month end that depends on the leap rule, a year wrap, a load while frozen, and an alarm match on the same edge as a clear. None of these can be reached by waiting for the counters to get there. The stimulus first sets refresh hold, writes a chosen time one second short of the boundary into the shadow fields, and raises the load bit. It then synchronises on `tick_o` so that the following tick crosses the boundary. For the set-against-clear case, the clear pulse is placed exactly on a tick cycle found the same way.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW = 8;   // bits per time field
  localparam int NF = 6;   // number of time fields
  localparam int AW = 4;   // register address width
  localparam int CW = 4;   // control register width

  // field index inside a field vector; also the mask bit position
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  // control bits
  localparam int C_LOAD = 0;
  localparam int C_HOLD = 1;
  localparam int C_FRZ  = 2;
  localparam int C_ARM  = 3;

  // register map
  localparam int A_CTRL = 0;
  localparam int A_MASK = 1;
  localparam int A_SHAD = 2;
  localparam int A_ALRM = A_SHAD + NF;

  // field limits
  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int MON_LAST  = 12;

  typedef logic [NF-1:0][FW-1:0] cal_fields_t;

  function automatic logic [FW-1:0] month_end(input logic [FW-1:0] mon,
                                              input logic [FW-1:0] yr);
    logic [FW-1:0] d;
    case (mon)
      FW'(4), FW'(6), FW'(9), FW'(11): d = FW'(30);
      FW'(2):  d = (yr[1:0] == 2'b00) ? FW'(29) : FW'(28);
      default: d = FW'(31);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == TW'(TICK_DIV - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + TW'(1);
      tick  <= 1'b0;
    end
  end

  // R1: a tick lasts one cycle
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/cal_counters.sv
module cal_counters
  import cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        load,
  input  logic        freeze,
  input  cal_fields_t load_val,
  output cal_fields_t now_q,
  output cal_fields_t nxt
);
  cal_fields_t inc;

  // one-second advance with carries through the calendar
  always_comb begin
    inc = now_q;
    if (now_q[F_SEC] >= FW'(SEC_LAST)) begin
      inc[F_SEC] = '0;
      if (now_q[F_MIN] >= FW'(MIN_LAST)) begin
        inc[F_MIN] = '0;
        if (now_q[F_HOUR] >= FW'(HOUR_LAST)) begin
          inc[F_HOUR] = '0;
          if (now_q[F_DAY] >= month_end(now_q[F_MON], now_q[F_YEAR])) begin
            inc[F_DAY] = FW'(1);
            if (now_q[F_MON] >= FW'(MON_LAST)) begin
              inc[F_MON]  = FW'(1);
              inc[F_YEAR] = now_q[F_YEAR] + FW'(1);
            end else begin
              inc[F_MON] = now_q[F_MON] + FW'(1);
            end
          end else begin
            inc[F_DAY] = now_q[F_DAY] + FW'(1);
          end
        end else begin
          inc[F_HOUR] = now_q[F_HOUR] + FW'(1);
        end
      end else begin
        inc[F_MIN] = now_q[F_MIN] + FW'(1);
      end
    end else begin
      inc[F_SEC] = now_q[F_SEC] + FW'(1);
    end
  end

  // load beats increment; freeze blocks only the increment
  always_comb begin
    if (tick && load)         nxt = load_val;
    else if (tick && !freeze) nxt = inc;
    else                      nxt = now_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q         <= '0;
      now_q[F_DAY]  <= FW'(1);
      now_q[F_MON]  <= FW'(1);
    end else begin
      now_q <= nxt;
    end
  end

  // R1: counters hold between ticks
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now_q));
  // R2: seconds wrap after 59
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !freeze && now_q[F_SEC] == FW'(SEC_LAST)) |=> (now_q[F_SEC] == '0));
  // R5: a load tick takes the host fields
  p_load_take_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && load) |=> (now_q == $past(load_val)));
  // R7: a frozen tick without load leaves the time unchanged
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && freeze) |=> $stable(now_q));
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          check,
  input  cal_fields_t   cur,
  input  cal_fields_t   alm,
  input  logic [NF-1:0] mask,
  input  logic          clr,
  output logic          alarm_n
);
  logic [NF-1:0] fld_ok;
  logic          hit;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_ok[g] = ~mask[g] | (cur[g] == alm[g]);
  end

  assign hit = check & (&fld_ok);

  // a new match wins over a release on the same edge
  always_ff @(posedge clk) begin
    if (rst)      alarm_n <= 1'b1;
    else if (hit) alarm_n <= 1'b0;
    else if (clr) alarm_n <= 1'b1;
  end

  // R8: the line stays low until cleared
  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!alarm_n && !clr) |=> !alarm_n);
  // R8: a clear with no match releases the line
  p_alarm_release_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> alarm_n);
  // R7: no evaluation means no new assertion of the line
  p_no_check_r7: assert property (@(posedge clk) disable iff (rst)
    (!check && alarm_n) |=> alarm_n);
endmodule

// File: rtl/cal_clock_alarm.sv
module cal_clock_alarm
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [FW-1:0] rd_data,
  input  logic          alarm_clr,
  output logic          tick_o,
  output logic          alarm_n
);
  logic          tick;
  logic [CW-1:0] ctrl_q;
  logic [NF-1:0] mask_q;
  cal_fields_t   shad_q;
  cal_fields_t   alrm_q;
  cal_fields_t   now_q;
  cal_fields_t   nxt;
  logic          check;
  logic [FW-1:0] rd_mux;

  cal_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cal_counters u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (ctrl_q[C_LOAD]),
    .freeze   (ctrl_q[C_FRZ]),
    .load_val (shad_q),
    .now_q    (now_q),
    .nxt      (nxt)
  );

  assign check = tick & ctrl_q[C_ARM] & ~ctrl_q[C_FRZ];

  cal_alarm u_alarm (
    .clk     (clk),
    .rst     (rst),
    .check   (check),
    .cur     (nxt),
    .alm     (alrm_q),
    .mask    (mask_q),
    .clr     (alarm_clr),
    .alarm_n (alarm_n)
  );

  assign tick_o = tick;

  // register window; host writes come last so they win
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= '0;
      mask_q        <= '1;
      shad_q        <= '0;
      shad_q[F_SEC] <= '1;
      alrm_q        <= '0;
      alrm_q[F_SEC] <= '1;
    end else begin
      if (tick && ctrl_q[C_LOAD]) ctrl_q[C_LOAD] <= 1'b0;
      if (tick && !ctrl_q[C_HOLD]) shad_q <= nxt;
      if (wr_en) begin
        if (wr_addr == AW'(A_CTRL)) ctrl_q <= wr_data[CW-1:0];
        if (wr_addr == AW'(A_MASK)) mask_q <= wr_data[NF-1:0];
        for (int i = 0; i < NF; i++) begin
          if (wr_addr == AW'(A_SHAD + i)) shad_q[i] <= wr_data;
          if (wr_addr == AW'(A_ALRM + i)) alrm_q[i] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(A_CTRL)) rd_mux = {{(FW-CW){1'b0}}, ctrl_q};
    if (rd_addr == AW'(A_MASK)) rd_mux = {{(FW-NF){1'b0}}, mask_q};
    for (int i = 0; i < NF; i++) begin
      if (rd_addr == AW'(A_SHAD + i)) rd_mux = shad_q[i];
      if (rd_addr == AW'(A_ALRM + i)) rd_mux = alrm_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R5: the load request clears itself on its tick unless rewritten
  p_load_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && ctrl_q[C_LOAD] && !(wr_en && wr_addr == AW'(A_CTRL))) |=> !ctrl_q[C_LOAD]);
  // R6: with refresh held and no host write, the shadow fields keep their value
  p_hold_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_HOLD] && !wr_en) |=> $stable(shad_q));
endmodule

// File: tb/cal_clock_alarm_bench.sv
module cal_clock_alarm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       alarm_clr = 1'b0;
  logic       tick_o;
  logic       alarm_n;

  cal_clock_alarm #(.TICK_DIV(TDIV)) u_cal_clock_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_clr(alarm_clr),
    .tick_o(tick_o), .alarm_n(alarm_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit         pin;
    logic [7:0] exp;
    int         due;
    string      tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk) cyc++;

  // monitor: compares queued expectations when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [7:0] got;
      it  = sb.pop_front();
      got = it.pin ? {7'b0, alarm_n} : rd_data;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic check_reg(input logic [3:0] a, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.pin = 1'b0; it.exp = e; it.due = cyc + 1; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic check_pin(input logic e, input string t);
    item_t it;
    @(negedge clk);
    it.pin = 1'b1; it.exp = {7'b0, e}; it.due = cyc + 1; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic direct(input int got, input int exp, input string t);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick_o) @(negedge clk);
  endtask

  task automatic clear_alarm();
    @(negedge clk);
    alarm_clr = 1'b1;
    @(posedge clk);
    #1 alarm_clr = 1'b0;
  endtask

  // stage a time in the shadow fields and load it on the next tick
  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s, input logic [7:0] ex);
    wait_tick();
    wr(4'd0, 8'h02 | ex);
    wr(4'd2, s); wr(4'd3, mi); wr(4'd4, h);
    wr(4'd5, d); wr(4'd6, mo); wr(4'd7, y);
    wr(4'd0, 8'h03 | ex);
    wait_tick();
    wr(4'd0, ex);
  endtask

  task automatic check_time(input logic [7:0] y, mo, d, h, mi, s, input string t);
    check_reg(4'd2, s,  {t, " second"});
    check_reg(4'd3, mi, {t, " minute"});
    check_reg(4'd4, h,  {t, " hour"});
    check_reg(4'd5, d,  {t, " day"});
    check_reg(4'd6, mo, {t, " month"});
    check_reg(4'd7, y,  {t, " year"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9 / R10 reset values through the read window
    check_reg(4'd2, 8'hFF, "R9 shadow second preset");
    check_reg(4'd8, 8'hFF, "R9 alarm second preset");
    check_reg(4'd1, 8'h3F, "R9 mask all ones");
    check_reg(4'd0, 8'h00, "R10 control reset");
    check_reg(4'd15, 8'h00, "R10 unmapped address");
    check_pin(1'b1, "R9 alarm released");

    // R1 first tick advances from the reset time
    wait_tick();
    check_time(8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd1, "R1 first tick");
    wait_tick();
    t0 = cyc;
    wait_tick();
    direct(cyc - t0, TDIV, "R1 tick period");

    // R2 carries through the clock
    set_time(8'd1, 8'd3, 8'd5, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd1, 8'd3, 8'd6, 8'd0, 8'd0, 8'd0, "R2 midnight carry");

    // R3 month lengths
    set_time(8'd9, 8'd4, 8'd30, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd9, 8'd5, 8'd1, 8'd0, 8'd0, 8'd0, "R3 end of 30-day month");
    set_time(8'd9, 8'd5, 8'd30, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd9, 8'd5, 8'd31, 8'd0, 8'd0, 8'd0, "R3 day 31 of long month");
    set_time(8'd4, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd4, 8'd2, 8'd29, 8'd0, 8'd0, 8'd0, "R3 leap February 29");
    set_time(8'd4, 8'd2, 8'd29, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd4, 8'd3, 8'd1, 8'd0, 8'd0, 8'd0, "R3 leap February end");
    set_time(8'd5, 8'd2, 8'd28, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd5, 8'd3, 8'd1, 8'd0, 8'd0, 8'd0, "R3 plain February end");

    // R4 month and year rollover
    set_time(8'd6, 8'd1, 8'd31, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd6, 8'd2, 8'd1, 8'd0, 8'd0, 8'd0, "R4 month step");
    set_time(8'd255, 8'd12, 8'd31, 8'd23, 8'd59, 8'd59, 8'h00);
    wait_tick();
    check_time(8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, "R4 year wrap");

    // R6 refresh hold keeps host value, release resumes refresh
    wait_tick();
    wr(4'd0, 8'h02);
    wr(4'd3, 8'h2A);
    wait_tick();
    wait_tick();
    check_reg(4'd3, 8'h2A, "R6 held shadow minute");
    wr(4'd0, 8'h00);
    wait_tick();
    check_reg(4'd3, 8'h00, "R6 refresh resumed");

    // R7 freeze stops counting; R5 load still works while frozen
    set_time(8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'h04);
    wait_tick();
    check_time(8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, "R7 frozen after R5 load");
    wait_tick();
    check_reg(4'd2, 8'd7, "R7 still frozen");

    // R5 load bit clears itself on its tick
    wr(4'd0, 8'h00);
    wait_tick();
    wr(4'd0, 8'h03);
    wait_tick();
    check_reg(4'd0, 8'h02, "R5 load self-clear");
    wr(4'd0, 8'h00);

    // R8 full match
    wr(4'd8, 8'd10); wr(4'd9, 8'd10); wr(4'd10, 8'd10);
    wr(4'd11, 8'd10); wr(4'd12, 8'd10); wr(4'd13, 8'd10);
    wr(4'd1, 8'h3F);
    set_time(8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd9, 8'h08);
    check_pin(1'b1, "R8 no match one second early");
    wait_tick();
    check_pin(1'b0, "R8 full match drives low");
    wait_tick();
    check_pin(1'b0, "R8 stays low without clear");
    clear_alarm();
    check_pin(1'b1, "R8 clear releases");

    // R8 second excluded by mask bit 0
    wr(4'd1, 8'h3E);
    set_time(8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 8'd40, 8'h08);
    check_pin(1'b0, "R8 masked second matches on load tick");
    clear_alarm();
    check_pin(1'b1, "R8 released before next tick");
    wait_tick();
    check_pin(1'b0, "R8 masked match each tick");
    wait_tick();
    alarm_clr = 1'b1;
    @(posedge clk);
    #1 alarm_clr = 1'b0;
    check_pin(1'b0, "R8 match beats clear on same edge");
    wr(4'd9, 8'd11);
    clear_alarm();
    check_pin(1'b1, "R8 released for mismatch test");
    wait_tick();
    check_pin(1'b1, "R8 unmasked minute mismatch blocks");

    // R7 arm bit and freeze gate the alarm
    wr(4'd0, 8'h00);
    wr(4'd9, 8'd10);
    wait_tick();
    check_pin(1'b1, "R7 disarmed no alarm");
    wr(4'd0, 8'h0C);
    wait_tick();
    check_pin(1'b1, "R7 frozen no alarm");
    wr(4'd0, 8'h08);
    wait_tick();
    check_pin(1'b0, "R8 armed match resumes");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule